// File: doc/BRIEF.md
# Half-Duplex Collision Jam and Backoff Controller

This block sits beside the transmit path of a half-duplex Ethernet MAC. Once an attempt begins, it counts bit-time strobes from the start of the frame and watches a collision input. When a collision arrives, it overrides the 4-bit transmit nibble path with an all-ones jam. If the collision came while the preamble was still being sent, the jam waits until the preamble is complete.

After the jam, the block does one of three things:
- If the collision came within the first slot time, it asks for a retry and waits a random number of slot times.
- If the collision came later than that, it reports a late collision and does not retry.
- If the attempt budget is used up, it reports a retry-limit error and gives the frame up.

A pulse marks the end of the backoff wait, so the deferral logic can take over.

The random backoff comes from a 16-bit linear feedback shift register. The register steps once for each backoff draw. Its low bits are masked to a window that doubles with each attempt, up to a cap. A frame that completes without a collision clears the attempt count.

Top module: `coljam_backoff_ctrl`

## Requirements
- R1: After reset, jam_active, retry_req, late_col_err, retry_limit_err and backoff_done are low, and jam_nibble equals tx_nibble.
- R2: While jam_active is high, jam_nibble is 4'hF. Otherwise jam_nibble equals tx_nibble in the same cycle.
- R3: A jam lasts exactly JAM_BITS (default 32) bit strobes. These are the strobes sampled in cycles where jam_active is high. A collision sampled while in_preamble is low raises jam_active in the next cycle.
- R4: A collision sampled while in_preamble is high keeps jam_active low until in_preamble falls. jam_active rises in the cycle after the first cycle in which in_preamble is low.
- R5: Bit strobes are counted from frame_start; the strobe in the frame_start cycle itself is not counted. A collision sampled when fewer than SLOT_BITS (default 512) strobes have been counted is early. A collision sampled at SLOT_BITS strobes or more is late.
- R6: A late collision gives a one-cycle late_col_err pulse in the cycle after jam_active falls. It gives no retry_req and no backoff_done, and it clears the attempt count.
- R7: An early collision that is within the limit gives a one-cycle retry_req pulse in the cycle after jam_active falls. It raises the attempt count n by one.
- R8: The backoff draw works as follows.
  - The register starts at 16'hACE1. Each draw steps it once: s becomes {s[14:0], s[15]^s[13]^s[12]^s[10]}. It does not step at any other time.
  - k is the stepped value ANDed with 2^min(n,10)-1.
  - The wait is W = k*SLOT_BITS strobes.
  - Strobes are counted from the retry_req cycle onward. backoff_done pulses for one cycle, one cycle after the first cycle that has W strobes counted before it. When W=0, it pulses one cycle after retry_req.
- R9: The collision that would be failed attempt number ATTEMPT_LIMIT (default 16) gives a one-cycle retry_limit_err pulse instead of retry_req, and it clears the attempt count.
- R10: A frame_done pulse during an attempt with no collision clears the attempt count, so the next draw uses n=1.
- R11: A collision sampled while no attempt is in progress, or during the backoff wait, has no effect: jam_active stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One pulse per bit time |
| frame_start | input | 1 | Pulse at the first preamble bit of an attempt |
| frame_done | input | 1 | Pulse when an attempt finishes without a collision |
| in_preamble | input | 1 | High while the preamble is being sent |
| col | input | 1 | Collision indication |
| tx_nibble | input | 4 | Normal transmit nibble |
| jam_active | output | 1 | High while the jam is being sent |
| jam_nibble | output | 4 | Nibble to the line: the jam or tx_nibble |
| retry_req | output | 1 | Pulse requesting a retransmission after backoff |
| late_col_err | output | 1 | Pulse: late collision, frame closed |
| retry_limit_err | output | 1 | Pulse: attempt limit reached, frame dropped |
| backoff_done | output | 1 | Pulse when the backoff wait expires |

## Verification
The block's results fall due at these times:

| Result | When it is due |
|---|---|
| jam_nibble | Combinational, in the same cycle |
| jam_active, data-phase collision | One cycle after the collision is sampled |
| jam_active, preamble collision | One cycle after the first cycle with in_preamble low |
| Outcome pulse (retry_req, late_col_err or retry_limit_err) | In the cycle where jam_active is first seen low |
| backoff_done | One cycle after the cycle in which the bench's own strobe count reaches k*SLOT_BITS |

The bench drives the inputs on the falling edge and samples the outputs there before it drives. It indexes every cycle from the frame_start cycle. From that index and from the strobes it has itself driven, it computes the exact cycle in which each output is due. It checks the output in that cycle and requires the output to stay quiet in every cycle before it.

// File: rtl/cjb_pkg.sv
package cjb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TX,
    ST_HOLD,
    ST_JAM,
    ST_BACKOFF
  } cjb_state_e;

  // one step of the 16-bit backoff shift register
  function automatic logic [15:0] lfsr_step(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // window mask 2^min(n,cap)-1
  function automatic logic [15:0] backoff_mask(input int unsigned n, input int unsigned cap);
    int unsigned e;
    e = (n < cap) ? n : cap;
    return 16'((32'd1 << e) - 32'd1);
  endfunction

endpackage

// File: rtl/cjb_slot_timer.sv
module cjb_slot_timer #(
  parameter int SLOT_BITS = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic bit_stb,
  output logic expired
);
  localparam int CNT_W = $clog2(SLOT_BITS + 1);

  logic [CNT_W-1:0] cnt_q;

  assign expired = (cnt_q == CNT_W'(SLOT_BITS));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      cnt_q <= '0;
    end else if (bit_stb && !expired) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cjb_jam_gen.sv
module cjb_jam_gen #(
  parameter int JAM_BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic bit_stb,
  output logic last
);
  localparam int CNT_W = $clog2(JAM_BITS + 1);

  logic [CNT_W-1:0] cnt_q;

  assign last = active && bit_stb && (cnt_q == CNT_W'(JAM_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      cnt_q <= '0;
    end else if (bit_stb) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/cjb_backoff.sv
module cjb_backoff #(
  parameter int          SLOT_BITS = 512,
  parameter int          CAP       = 10,
  parameter logic [15:0] SEED      = 16'hACE1,
  parameter int          ATT_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             draw,
  input  logic [ATT_W-1:0] attempt,
  input  logic             waiting,
  input  logic             bit_stb,
  output logic             wait_zero
);
  import cjb_pkg::*;

  localparam int SLOT_W = $clog2(SLOT_BITS + 1);
  localparam int REM_W  = CAP + SLOT_W;

  logic [15:0]      lfsr_q;
  logic [15:0]      lfsr_nx;
  logic [15:0]      win_mask;
  logic [CAP-1:0]   k_draw;
  logic [REM_W-1:0] rem_q;
  logic [REM_W-1:0] rem_load;

  always_comb begin
    lfsr_nx  = lfsr_step(lfsr_q);
    win_mask = backoff_mask(int'(attempt), CAP);
    k_draw   = lfsr_nx[CAP-1:0] & win_mask[CAP-1:0];
    rem_load = REM_W'(k_draw) * REM_W'(SLOT_BITS);
  end

  assign wait_zero = (rem_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q <= SEED;
      rem_q  <= '0;
    end else if (draw) begin
      lfsr_q <= lfsr_nx;
      rem_q  <= rem_load;
    end else if (waiting && bit_stb && !wait_zero) begin
      rem_q <= rem_q - 1'b1;
    end
  end
endmodule

// File: rtl/coljam_backoff_ctrl.sv
module coljam_backoff_ctrl #(
  parameter int          SLOT_BITS     = 512,
  parameter int          JAM_BITS      = 32,
  parameter int          ATTEMPT_LIMIT = 16,
  parameter int          BACKOFF_CAP   = 10,
  parameter logic [15:0] LFSR_SEED     = 16'hACE1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_stb,
  input  logic       frame_start,
  input  logic       frame_done,
  input  logic       in_preamble,
  input  logic       col,
  input  logic [3:0] tx_nibble,
  output logic       jam_active,
  output logic [3:0] jam_nibble,
  output logic       retry_req,
  output logic       late_col_err,
  output logic       retry_limit_err,
  output logic       backoff_done
);
  import cjb_pkg::*;

  localparam int ATT_W = $clog2(ATTEMPT_LIMIT + 1);

  cjb_state_e       state_q, state_d;
  logic [ATT_W-1:0] att_q;
  logic             late_q;

  // named internal events
  logic ev_col_accept;
  logic ev_jam_last;
  logic ev_retry;
  logic ev_late;
  logic ev_limit;
  logic ev_wait_over;
  logic ev_success;
  logic slot_expired;
  logic wait_zero;
  logic in_backoff;

  assign jam_active = (state_q == ST_JAM);
  assign in_backoff = (state_q == ST_BACKOFF);
  assign jam_nibble = jam_active ? 4'hF : tx_nibble;

  cjb_slot_timer #(.SLOT_BITS(SLOT_BITS)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (frame_start && (state_q == ST_IDLE)),
    .bit_stb (bit_stb),
    .expired (slot_expired)
  );

  cjb_jam_gen #(.JAM_BITS(JAM_BITS)) u_jam (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (jam_active),
    .bit_stb (bit_stb),
    .last    (ev_jam_last)
  );

  cjb_backoff #(
    .SLOT_BITS (SLOT_BITS),
    .CAP       (BACKOFF_CAP),
    .SEED      (LFSR_SEED),
    .ATT_W     (ATT_W)
  ) u_bo (
    .clk       (clk),
    .rst_n     (rst_n),
    .draw      (ev_retry),
    .attempt   (att_q + 1'b1),
    .waiting   (in_backoff),
    .bit_stb   (bit_stb),
    .wait_zero (wait_zero)
  );

  always_comb begin
    ev_col_accept = (state_q == ST_TX) && col;
    ev_success    = (state_q == ST_TX) && !col && frame_done;
    ev_late       = ev_jam_last && late_q;
    ev_limit      = ev_jam_last && !late_q && (att_q == ATT_W'(ATTEMPT_LIMIT - 1));
    ev_retry      = ev_jam_last && !late_q && (att_q != ATT_W'(ATTEMPT_LIMIT - 1));
    ev_wait_over  = in_backoff && wait_zero;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (frame_start) state_d = ST_TX;
      ST_TX: begin
        if (ev_col_accept)   state_d = in_preamble ? ST_HOLD : ST_JAM;
        else if (ev_success) state_d = ST_IDLE;
      end
      ST_HOLD:    if (!in_preamble) state_d = ST_JAM;
      ST_JAM: begin
        if (ev_retry)                  state_d = ST_BACKOFF;
        else if (ev_late || ev_limit)  state_d = ST_IDLE;
      end
      ST_BACKOFF: if (ev_wait_over) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q         <= ST_IDLE;
      att_q           <= '0;
      late_q          <= 1'b0;
      retry_req       <= 1'b0;
      late_col_err    <= 1'b0;
      retry_limit_err <= 1'b0;
      backoff_done    <= 1'b0;
    end else begin
      state_q         <= state_d;
      retry_req       <= ev_retry;
      late_col_err    <= ev_late;
      retry_limit_err <= ev_limit;
      backoff_done    <= ev_wait_over;
      if (ev_col_accept) late_q <= slot_expired;
      if (ev_success || ev_late || ev_limit) begin
        att_q <= '0;
      end else if (ev_retry) begin
        att_q <= att_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cjb_checker.sv
module cjb_checker #(
  parameter int JAM_BITS = 32
) (
  input logic clk,
  input logic rst_n,
  input logic bit_stb,
  input logic in_preamble,
  input logic jam_active,
  input logic retry_req,
  input logic late_col_err,
  input logic retry_limit_err,
  input logic backoff_done
);
  localparam int JC_W = $clog2(JAM_BITS + 1) + 1;

  logic [JC_W-1:0] jcnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !jam_active) jcnt_q <= '0;
    else if (bit_stb)          jcnt_q <= jcnt_q + 1'b1;
  end

  p_jam_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(jam_active) |-> (jcnt_q == JC_W'(JAM_BITS)));

  p_jam_after_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(jam_active) |-> !$past(in_preamble));

  p_one_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({retry_req, late_col_err, retry_limit_err}));

  p_late_after_jam_r6: assert property (@(posedge clk) disable iff (!rst_n)
    late_col_err |-> ($past(jam_active) && !jam_active));

  p_retry_after_jam_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retry_req |-> ($past(jam_active) && !jam_active));

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_done |-> (!jam_active && !$past(jam_active)));

  p_limit_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    retry_limit_err |=> !retry_limit_err);
endmodule

bind coljam_backoff_ctrl cjb_checker #(.JAM_BITS(JAM_BITS)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .bit_stb         (bit_stb),
  .in_preamble     (in_preamble),
  .jam_active      (jam_active),
  .retry_req       (retry_req),
  .late_col_err    (late_col_err),
  .retry_limit_err (retry_limit_err),
  .backoff_done    (backoff_done)
);

// File: tb/coljam_backoff_ctrl_tb_top.sv
module coljam_backoff_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAIN_SLOT  = 512;
  localparam int LIM_SLOT   = 8;
  localparam int JAM_LEN    = 32;
  localparam int LIMIT      = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 1'b0;
  logic bit_stb = 1'b0, frame_start = 1'b0, frame_done = 1'b0, in_preamble = 1'b0, col = 1'b0;
  logic [3:0] tx_nibble = 4'h0;

  logic m_jam, m_retry, m_late, m_lim, m_done;
  logic l_jam, l_retry, l_late, l_lim, l_done;
  logic [3:0] m_nib, l_nib;

  logic o_jam, o_retry, o_late, o_lim, o_done;
  logic [3:0] o_nib;

  int tests = 0;
  int fails = 0;
  int att [2];
  logic [15:0] lfsr [2];
  bit last_late;
  bit last_lim;

  always #(CLK_PERIOD/2) clk = ~clk;

  coljam_backoff_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .bit_stb(bit_stb && !sel), .frame_start(frame_start && !sel),
    .frame_done(frame_done && !sel), .in_preamble(in_preamble && !sel),
    .col(col && !sel), .tx_nibble(tx_nibble),
    .jam_active(m_jam), .jam_nibble(m_nib), .retry_req(m_retry),
    .late_col_err(m_late), .retry_limit_err(m_lim), .backoff_done(m_done)
  );

  coljam_backoff_ctrl #(.SLOT_BITS(LIM_SLOT)) dut_lim_i (
    .clk(clk), .rst_n(rst_n),
    .bit_stb(bit_stb && sel), .frame_start(frame_start && sel),
    .frame_done(frame_done && sel), .in_preamble(in_preamble && sel),
    .col(col && sel), .tx_nibble(tx_nibble),
    .jam_active(l_jam), .jam_nibble(l_nib), .retry_req(l_retry),
    .late_col_err(l_late), .retry_limit_err(l_lim), .backoff_done(l_done)
  );

  assign o_jam   = sel ? l_jam   : m_jam;
  assign o_nib   = sel ? l_nib   : m_nib;
  assign o_retry = sel ? l_retry : m_retry;
  assign o_late  = sel ? l_late  : m_late;
  assign o_lim   = sel ? l_lim   : m_lim;
  assign o_done  = sel ? l_done  : m_done;

  function automatic logic [15:0] tb_step(input logic [15:0] s);
    logic fb;
    fb = ^(s & 16'hB400);
    return (s << 1) | {15'd0, fb};
  endfunction

  function automatic int tb_window(input int n);
    int e;
    e = (n > 10) ? 10 : n;
    return (1 << e) - 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic pick_stb(input bit rnd);
    return rnd ? logic'($urandom_range(0, 3) != 0) : 1'b1;
  endfunction

  task automatic clear_frame();
    @(negedge clk); frame_start = 1'b1; bit_stb = 1'b1;
    @(negedge clk); frame_start = 1'b0; frame_done = 1'b1;
    @(negedge clk); frame_done = 1'b0;
    att[sel] = 0;
  endtask

  task automatic attempt(input int j, input int pre_len, input bit rnd,
                         input bit col_bo, input string btag);
    int slot, bits, first_jam, jam_str, i, nib_bad, exp_first, k, wait_len, cnt, guard, idx;
    bit late, expect_done, jam_in_bo;
    idx = int'(sel);
    slot = sel ? LIM_SLOT : MAIN_SLOT;
    bits = 0; first_jam = -1; jam_str = 0; nib_bad = 0; late = 1'b0; i = 0;
    @(negedge clk);
    frame_start = 1'b1; col = 1'b0; in_preamble = (pre_len > 0); bit_stb = 1'b1;
    forever begin
      @(negedge clk); i++;
      if (o_jam) begin
        if (first_jam < 0) first_jam = i;
        if (o_nib != 4'hF) nib_bad++;
      end else begin
        if (o_nib != tx_nibble) nib_bad++;
        if (first_jam >= 0) break;
      end
      if (i > j + pre_len + 400) break;
      frame_start = 1'b0;
      in_preamble = (i <= pre_len);
      col = (i == j + 1);
      if (i == j + 1) late = (bits >= slot);
      bit_stb = pick_stb(rnd);
      tx_nibble = 4'($urandom);
      bits += int'(bit_stb);
      if (o_jam && bit_stb) jam_str++;
    end
    col = 1'b0;
    exp_first = (j + 1 <= pre_len) ? pre_len + 2 : j + 2;
    if (j + 1 <= pre_len) chk(first_jam == exp_first, "R4 jam start after preamble", first_jam, exp_first);
    else                  chk(first_jam == exp_first, "R3 jam start", first_jam, exp_first);
    chk(jam_str == JAM_LEN, "R3 jam strobes", jam_str, JAM_LEN);
    chk(nib_bad == 0, "R2 nibble mux", nib_bad, 0);
    last_late = o_late;
    last_lim  = o_lim;
    if (late) begin
      chk(o_late && !o_retry && !o_lim && !o_done, "R6 late outcome",
          int'({o_late, o_retry, o_lim}), 4);
      att[idx] = 0;
    end else if (att[idx] == LIMIT - 1) begin
      chk(o_lim && !o_retry && !o_late, "R9 limit outcome",
          int'({o_late, o_retry, o_lim}), 1);
      att[idx] = 0;
    end else begin
      att[idx]++;
      lfsr[idx] = tb_step(lfsr[idx]);
      k = int'(lfsr[idx]) & tb_window(att[idx]);
      wait_len = k * slot;
      chk(o_retry && !o_late && !o_lim, "R7 retry outcome",
          int'({o_late, o_retry, o_lim}), 2);
      cnt = 0; guard = 0; jam_in_bo = 1'b0;
      expect_done = (wait_len == 0);
      col = col_bo;
      bit_stb = pick_stb(rnd);
      cnt += int'(bit_stb);
      forever begin
        @(negedge clk); guard++;
        if (o_jam) jam_in_bo = 1'b1;
        if (expect_done) begin
          chk(o_done == 1'b1, btag, int'(o_done), 1);
          break;
        end
        if (o_done) begin
          chk(1'b0, btag, cnt, wait_len);
          break;
        end
        if (guard > wait_len * 4 + 20) begin
          chk(1'b0, btag, guard, wait_len);
          break;
        end
        expect_done = (cnt == wait_len);
        col = 1'b0;
        bit_stb = pick_stb(rnd);
        cnt += int'(bit_stb);
      end
      col = 1'b0;
      if (col_bo) chk(!jam_in_bo, "R11 collision in backoff", int'(jam_in_bo), 0);
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed_sink;
    seed_sink = int'($urandom(32'h5EED));
    att[0] = 0; att[1] = 0;
    lfsr[0] = 16'hACE1; lfsr[1] = 16'hACE1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; tx_nibble = 4'h6;
    @(negedge clk);
    // R1 reset state
    chk(!o_jam && !o_retry && !o_late && !o_lim && !o_done, "R1 outputs after reset",
        int'({o_jam, o_retry, o_late, o_lim, o_done}), 0);
    chk(o_nib == 4'h6, "R1 nibble passthrough", int'(o_nib), 6);

    // R11 collision while idle
    col = 1'b1; bit_stb = 1'b1;
    @(negedge clk); col = 1'b0;
    begin
      int seen;
      seen = 0;
      for (int c = 0; c < 4; c++) begin
        @(negedge clk);
        if (o_jam || o_retry || o_late) seen++;
      end
      chk(seen == 0, "R11 collision while idle", seen, 0);
    end

    attempt(5, 2, 1'b0, 1'b0, "R8 backoff wait data");
    attempt(3, 16, 1'b0, 1'b1, "R8 backoff wait preamble");
    clear_frame();
    attempt(7, 4, 1'b1, 1'b0, "R10 draw after frame_done");

    // R5 slot boundary
    clear_frame();
    attempt(MAIN_SLOT - 1, 16, 1'b0, 1'b0, "R8 backoff wait slot edge");
    chk(!last_late, "R5 collision at 511 bits is early", int'(last_late), 0);
    clear_frame();
    attempt(MAIN_SLOT, 16, 1'b0, 1'b0, "R8 unused");
    chk(last_late, "R5 collision at 512 bits is late", int'(last_late), 1);

    for (int t = 0; t < 8; t++) begin
      if (att[0] >= 2) clear_frame();
      attempt($urandom_range(0, 700), $urandom_range(0, 20), 1'b1, 1'b0, "R8 random backoff");
    end

    // R9 attempt limit on the short-slot instance
    @(negedge clk); sel = 1'b1;
    for (int a = 0; a < LIMIT; a++) attempt(2, 0, 1'b0, 1'b0, "R9 backoff wait");
    chk(last_lim, "R9 limit error on 16th failure", int'(last_lim), 1);
    attempt(2, 0, 1'b0, 1'b0, "R9 count cleared after limit");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule